// File: doc/BRIEF.md
# Buffer-to-Burst Transfer Splitter

The splitter accepts one buffer request: start address, length in beats, beat size, whether the far end is plain memory or a peripheral, and for a peripheral whether it works in single transactions or in chunks of a programmed length. It then drives the address-phase signals of an AHB-style master port (`haddr`, `htrans`, `hburst`, `hsize`) until every beat of the buffer has been accepted with `hready` high.

Memory buffers go straight to bus accesses. Full 16-beat incrementing bursts are issued while at least 16 beats remain, and any shorter tail is issued as single accesses. A peripheral buffer first passes through a transaction layer. Each transaction waits for the peripheral's request, runs its beats through the same burst/single cut, and ends with a one-cycle acknowledge. A one-cycle done pulse marks the end of the whole buffer.

The controller has four states:

- `ST_IDLE`: waits for `start`. It goes to `ST_FINISH` when the length is zero, to `ST_WAIT_REQ` for a peripheral, and to `ST_BEAT` for memory.
- `ST_WAIT_REQ`: holds the bus idle. It goes to `ST_BEAT` when `periph_req` is sampled high while no acknowledge is being shown.
- `ST_BEAT`: issues beats. It goes to `ST_FINISH` when the buffer's last beat is accepted. It goes back to `ST_WAIT_REQ` when a peripheral transaction's last beat is accepted and beats remain.
- `ST_FINISH`: shows `done` for one cycle and returns to `ST_IDLE`.

Top module: `burst_splitter`

## Requirements
- R1: A request with a length of zero raises `done` in the cycle after `start` is sampled, and no bus access is made.
- R2: In memory mode, each run of 16 beats while 16 or more remain is one burst: `htrans`=NONSEQ (2'b10) on its first beat and SEQ (2'b11) on the next 15, with `hburst`=INCR16 (3'b111). No acknowledge is raised in this mode.
- R3: No burst exceeds 16 beats. Every beat outside a burst is a single access: NONSEQ with `hburst`=SINGLE (3'b000).
- R4: `hsize` equals the requested beat size. `haddr` starts at the start address and grows by 2**size bytes after every accepted beat.
- R5: While `htrans` is not IDLE (2'b00) and `hready` is low, `haddr`, `htrans` and `hburst` hold their values into the next cycle.
- R6: In peripheral mode, no bus access is made until `periph_req` has been sampled high for that transaction.
- R7: In peripheral single mode (`chunk_mode`=0), each transaction is exactly one single access. A one-cycle `periph_ack` follows it in the cycle after that beat is accepted.
- R8: In peripheral chunk mode (`chunk_mode`=1), each transaction is `chunk_beats` beats long (a value of 0 counts as 1), or fewer for the last one. Each transaction is cut into bursts and singles as in R2/R3, and each one ends with a one-cycle `periph_ack`.
- R9: `done` is high for exactly one cycle, the cycle after the last beat of the buffer is accepted. `busy` is high from the cycle after `start` until `done` ends.
- R10: A `start` pulse while `busy` is high is ignored and does not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a buffer request (sampled in idle only) |
| start_addr | input | AW | First beat address |
| beat_count | input | LW | Buffer length in beats |
| beat_size | input | 3 | Beat size code, bytes = 2**beat_size |
| periph_mode | input | 1 | 1 = far end is a handshaking peripheral |
| chunk_mode | input | 1 | Peripheral transaction type: 0 single, 1 chunk |
| chunk_beats | input | CW | Programmed chunk length in beats |
| periph_req | input | 1 | Peripheral request for the next transaction |
| periph_ack | output | 1 | One-cycle acknowledge after a transaction's last beat |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-buffer pulse |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hburst | output | 3 | Bus burst type |
| hsize | output | 3 | Bus beat size |
| hready | input | 1 | Bus ready; low stalls the current beat |

## Verification
The last beat of the last peripheral transaction ends two things at the same clock edge: the transaction acknowledge and the whole buffer. So `periph_ack` and `done` rise together in one cycle. A chunked peripheral buffer with a short final chunk provokes this. It is judged by requiring exactly one acknowledge per transaction and requiring the final acknowledge to fall in the same cycle as the single `done` pulse. A second collision, a stall arriving on a burst's first or last beat, is provoked with a periodic `hready` pattern and judged cycle by cycle against the held address and type.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_BEAT,
        ST_FINISH
    } bsplit_state_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;
    localparam logic [2:0] BU_INCR4  = 3'b011;
    localparam logic [2:0] BU_INCR8  = 3'b101;
    localparam logic [2:0] BU_INCR16 = 3'b111;

endpackage

// File: rtl/bsplit_xact_len.sv
module bsplit_xact_len #(
    parameter int LW = 16,
    parameter int CW = 8
) (
    input  logic [LW-1:0] rem_beats,
    input  logic          periph,
    input  logic          chunked,
    input  logic [CW-1:0] chunk_beats,
    output logic [LW-1:0] unit_beats
);
    logic [LW-1:0] chunk_ext;

    always_comb begin
        chunk_ext = (chunk_beats == '0) ? LW'(1) : LW'(chunk_beats);
        if (!periph) begin
            unit_beats = rem_beats;
        end else if (!chunked) begin
            unit_beats = LW'(1);
        end else if (chunk_ext < rem_beats) begin
            unit_beats = chunk_ext;
        end else begin
            unit_beats = rem_beats;
        end
    end
endmodule

// File: rtl/bsplit_burst_pick.sv
module bsplit_burst_pick #(
    parameter int LW        = 16,
    parameter int MAX_BURST = 16,
    localparam int BW       = $clog2(MAX_BURST + 1)
) (
    input  logic [LW-1:0] unit_left,
    output logic [BW-1:0] run_len,
    output logic [2:0]    run_code
);
    import bsplit_pkg::*;

    logic [2:0] burst_code;

    generate
        if (MAX_BURST == 16) begin : g_incr16
            assign burst_code = BU_INCR16;
        end else if (MAX_BURST == 8) begin : g_incr8
            assign burst_code = BU_INCR8;
        end else if (MAX_BURST == 4) begin : g_incr4
            assign burst_code = BU_INCR4;
        end else begin : g_incr
            assign burst_code = BU_INCR;
        end
    endgenerate

    always_comb begin
        if (unit_left >= LW'(MAX_BURST)) begin
            run_len  = BW'(MAX_BURST);
            run_code = burst_code;
        end else begin
            run_len  = BW'(1);
            run_code = BU_SINGLE;
        end
    end
endmodule

// File: rtl/bsplit_addr_step.sv
module bsplit_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_cur,
    input  logic [2:0]    size_code,
    output logic [AW-1:0] addr_next
);
    always_comb begin
        addr_next = addr_cur + (AW'(1) << size_code);
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
    parameter int AW        = 32,
    parameter int LW        = 16,
    parameter int CW        = 8,
    parameter int MAX_BURST = 16,
    localparam int BW       = $clog2(MAX_BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] beat_count,
    input  logic [2:0]    beat_size,
    input  logic          periph_mode,
    input  logic          chunk_mode,
    input  logic [CW-1:0] chunk_beats,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    output logic [2:0]    hsize,
    input  logic          hready
);
    import bsplit_pkg::*;

    bsplit_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] unit_q;
    logic [BW-1:0] run_q;
    logic [2:0]    kind_q;
    logic [2:0]    size_q;
    logic          periph_q;
    logic          chunked_q;
    logic [CW-1:0] chunk_q;
    logic          ack_q;

    logic [LW-1:0] xact_len;
    logic [BW-1:0] pick_len;
    logic [2:0]    pick_code;
    logic [AW-1:0] addr_nx;
    logic          accept;
    logic          first_beat;

    bsplit_xact_len #(.LW(LW), .CW(CW)) u_xact (
        .rem_beats   (rem_q),
        .periph      (periph_q),
        .chunked     (chunked_q),
        .chunk_beats (chunk_q),
        .unit_beats  (xact_len)
    );

    bsplit_burst_pick #(.LW(LW), .MAX_BURST(MAX_BURST)) u_pick (
        .unit_left (unit_q),
        .run_len   (pick_len),
        .run_code  (pick_code)
    );

    bsplit_addr_step #(.AW(AW)) u_step (
        .addr_cur  (addr_q),
        .size_code (size_q),
        .addr_next (addr_nx)
    );

    assign first_beat = (run_q == '0);
    assign accept     = (state_q == ST_BEAT) && hready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (beat_count == '0)   state_d = ST_FINISH;
                    else if (periph_mode)   state_d = ST_WAIT_REQ;
                    else                    state_d = ST_BEAT;
                end
            end
            ST_WAIT_REQ: begin
                if (periph_req && !ack_q) state_d = ST_BEAT;
            end
            ST_BEAT: begin
                if (accept) begin
                    if (rem_q == LW'(1))                   state_d = ST_FINISH;
                    else if (periph_q && unit_q == LW'(1)) state_d = ST_WAIT_REQ;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rem_q     <= '0;
            unit_q    <= '0;
            run_q     <= '0;
            kind_q    <= BU_SINGLE;
            size_q    <= '0;
            periph_q  <= 1'b0;
            chunked_q <= 1'b0;
            chunk_q   <= '0;
            ack_q     <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                addr_q    <= start_addr;
                rem_q     <= beat_count;
                unit_q    <= beat_count;
                run_q     <= '0;
                size_q    <= beat_size;
                periph_q  <= periph_mode;
                chunked_q <= chunk_mode;
                chunk_q   <= chunk_beats;
            end else if (state_q == ST_WAIT_REQ && periph_req && !ack_q) begin
                unit_q <= xact_len;
                run_q  <= '0;
            end else if (accept) begin
                addr_q <= addr_nx;
                rem_q  <= rem_q - LW'(1);
                unit_q <= unit_q - LW'(1);
                if (first_beat) begin
                    run_q  <= pick_len - BW'(1);
                    kind_q <= pick_code;
                end else begin
                    run_q <= run_q - BW'(1);
                end
                ack_q <= periph_q && (unit_q == LW'(1));
            end
        end
    end

    // outputs
    always_comb begin
        haddr      = addr_q;
        hsize      = size_q;
        periph_ack = ack_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        htrans     = TR_IDLE;
        hburst     = BU_SINGLE;
        if (state_q == ST_BEAT) begin
            htrans = first_beat ? TR_NONSEQ : TR_SEQ;
            hburst = first_beat ? pick_code : kind_q;
        end
    end

    // burst length tracker for the burst cap check
    logic [LW-1:0] seen_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_run <= '0;
        end else if (htrans != TR_IDLE && hready) begin
            if (htrans == TR_NONSEQ) seen_run <= LW'(1);
            else                     seen_run <= seen_run + LW'(1);
        end
    end

    a_r3_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        seen_run <= LW'(MAX_BURST));

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && !hready) |=>
        (haddr == $past(haddr) && htrans == $past(htrans) && hburst == $past(hburst)));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != TR_IDLE && hready && rem_q > LW'(1)) |=>
        (haddr == $past(haddr) + (AW'(1) << hsize)));

    a_r6_wait_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REQ && !periph_req) |=> (htrans == TR_IDLE));

    a_r1_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && beat_count == '0) |=> (done && htrans == TR_IDLE));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack);

    a_r2_mem_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !periph_q) |-> !periph_ack);

endmodule

// File: tb/burst_splitter_bench.sv
module burst_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] beat_count = '0;
    logic [2:0]  beat_size = '0;
    logic        periph_mode = 1'b0;
    logic        chunk_mode = 1'b0;
    logic [7:0]  chunk_beats = '0;
    logic        periph_req = 1'b0;
    logic        periph_ack, busy, done;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hburst, hsize;
    logic        hready = 1'b1;

    burst_splitter u_burst_splitter (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .beat_count(beat_count), .beat_size(beat_size), .periph_mode(periph_mode),
        .chunk_mode(chunk_mode), .chunk_beats(chunk_beats), .periph_req(periph_req),
        .periph_ack(periph_ack), .busy(busy), .done(done), .haddr(haddr),
        .htrans(htrans), .hburst(hburst), .hsize(hsize), .hready(hready)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor state
    int          cyc = 0;
    bit          mon_on = 0;
    bit          granted = 0;
    int          nb, ndone, nack, done_cyc, last_acc, last_ack_cyc, start_cyc;
    int          r6_bad, stall_seen, stall_bad, size_bad, busy_bad;
    logic [31:0] got_addr [0:255];
    logic [1:0]  got_trans[0:255];
    logic [2:0]  got_burst[0:255];
    bit          prev_stall = 0;
    logic [31:0] p_addr;
    logic [1:0]  p_trans;
    logic [2:0]  p_burst;
    logic [2:0]  exp_size;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (start && start_cyc < 0) start_cyc = cyc;
            if (prev_stall) begin
                stall_seen++;
                if (haddr !== p_addr || htrans !== p_trans || hburst !== p_burst) stall_bad++;
            end
            if (htrans[1] && hready) begin
                if (nb < 256) begin
                    got_addr[nb] = haddr; got_trans[nb] = htrans; got_burst[nb] = hburst;
                end
                if (hsize !== exp_size) size_bad++;
                nb++;
                last_acc = cyc;
                if (periph_mode && !granted) r6_bad++;
            end
            if (done) begin ndone++; done_cyc = cyc; end
            if (periph_ack) begin nack++; last_ack_cyc = cyc; end
            if (start_cyc >= 0 && cyc > start_cyc && ndone == 0 && !busy) busy_bad++;
            prev_stall = htrans[1] && !hready;
            p_addr = haddr; p_trans = htrans; p_burst = hburst;
        end
    end

    bit xfer_over = 0;

    task automatic responder();
        while (!xfer_over) begin
            repeat (3) @(posedge clk);
            #1;
            if (xfer_over) break;
            periph_req = 1'b1;
            granted = 1;
            do begin
                @(posedge clk); #1;
            end while (!periph_ack && !xfer_over);
            periph_req = 1'b0;
            granted = 0;
        end
    endtask

    task automatic stall_driver();
        int k = 0;
        while (!xfer_over) begin
            @(posedge clk); #1;
            k++;
            hready = (k % 3) != 0;
        end
        hready = 1'b1;
    endtask

    task automatic disturber();
        repeat (8) @(posedge clk);
        #1;
        if (!xfer_over) begin
            start = 1'b1; beat_count = 16'd3; start_addr = 32'hDEAD_0000;
            @(posedge clk); #1;
            start = 1'b0;
        end
    endtask

    // runs one buffer request and compares against a model built from the requirements
    task automatic run_xfer(input string tag, input logic [31:0] a0, input int len,
                            input int sz, input bit per, input bit chk, input int chunk,
                            input bit stall, input bit disturb);
        logic [31:0] e_addr [0:255];
        logic [1:0]  e_trans[0:255];
        logic [2:0]  e_burst[0:255];
        int rem, u, idx, nx, cu;
        logic [31:0] a;
        rem = len; idx = 0; nx = 0; a = a0;
        while (rem > 0) begin
            cu = (chunk == 0) ? 1 : chunk;
            u = !per ? rem : (!chk ? 1 : ((cu < rem) ? cu : rem));
            nx++; rem -= u;
            while (u > 0) begin
                if (u >= 16) begin
                    for (int k = 0; k < 16; k++) begin
                        e_addr[idx] = a; e_trans[idx] = (k == 0) ? 2'b10 : 2'b11;
                        e_burst[idx] = 3'b111; a += (32'd1 << sz); idx++;
                    end
                    u -= 16;
                end else begin
                    e_addr[idx] = a; e_trans[idx] = 2'b10; e_burst[idx] = 3'b000;
                    a += (32'd1 << sz); idx++; u--;
                end
            end
        end

        nb = 0; ndone = 0; nack = 0; done_cyc = -1; last_acc = -1; last_ack_cyc = -1;
        start_cyc = -1; r6_bad = 0; stall_seen = 0; stall_bad = 0; size_bad = 0; busy_bad = 0;
        prev_stall = 0; xfer_over = 0; exp_size = 3'(sz);

        @(posedge clk); #1;
        start_addr = a0; beat_count = 16'(len); beat_size = 3'(sz);
        periph_mode = per; chunk_mode = chk; chunk_beats = 8'(chunk);
        mon_on = 1; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        fork
            begin
                while (ndone == 0) @(posedge clk);
                #1; xfer_over = 1;
            end
            if (per) responder();
            if (stall) stall_driver();
            if (disturb) disturber();
        join
        repeat (3) @(posedge clk);
        #1; mon_on = 0;

        check(nb == idx, {tag, " beat count"}, nb, idx);
        for (int i = 0; i < idx && i < nb; i++) begin
            check(got_addr[i] == e_addr[i], {tag, " R4 address"}, got_addr[i], e_addr[i]);
            check(got_trans[i] == e_trans[i], {tag, " R2/R3 htrans"}, got_trans[i], e_trans[i]);
            check(got_burst[i] == e_burst[i], {tag, " R2/R3 hburst"}, got_burst[i], e_burst[i]);
        end
        check(size_bad == 0, {tag, " R4 hsize"}, size_bad, 0);
        check(ndone == 1, {tag, " R9 done count"}, ndone, 1);
        check(busy_bad == 0, {tag, " R9 busy"}, busy_bad, 0);
        if (len > 0)
            check(done_cyc == last_acc + 1, {tag, " R9 done timing"}, done_cyc, last_acc + 1);
        else
            check(done_cyc == start_cyc + 1, {tag, " R1 zero length done timing"}, done_cyc, start_cyc + 1);
        check(nack == (per ? nx : 0), {tag, " R7/R8 ack count"}, nack, per ? nx : 0);
        if (per && len > 0)
            check(last_ack_cyc == done_cyc, {tag, " R8 final ack with done"}, last_ack_cyc, done_cyc);
        if (per) check(r6_bad == 0, {tag, " R6 access before request"}, r6_bad, 0);
        if (stall) begin
            check(stall_seen > 0, {tag, " R5 stalls provoked"}, stall_seen, 1);
            check(stall_bad == 0, {tag, " R5 stall hold"}, stall_bad, 0);
        end
    endtask

    task automatic test_reset();
        check(htrans == 2'b00, "reset htrans idle", htrans, 0);
        check(done == 1'b0, "reset done low (R9)", done, 0);
        check(busy == 1'b0, "reset busy low (R9)", busy, 0);
        check(periph_ack == 1'b0, "reset ack low (R7)", periph_ack, 0);
    endtask

    task automatic test_r1_zero();        run_xfer("R1 zero", 32'h40, 0, 2, 0, 0, 0, 0, 0); endtask
    task automatic test_r2_memory();      run_xfer("R2 mem", 32'h100, 37, 2, 0, 0, 0, 0, 0); endtask
    task automatic test_r3_short_mem();   run_xfer("R3 short", 32'h200, 15, 0, 0, 0, 0, 0, 0); endtask
    task automatic test_r5_stall();       run_xfer("R5 stall", 32'h300, 20, 1, 0, 0, 0, 1, 0); endtask
    task automatic test_r7_single();      run_xfer("R7 single", 32'h400, 3, 2, 1, 0, 0, 0, 0); endtask
    task automatic test_r8_chunk();       run_xfer("R8 chunk", 32'h800, 45, 2, 1, 1, 20, 0, 0); endtask
    task automatic test_r8_chunk_stall(); run_xfer("R8 chunk stall", 32'h1000, 18, 3, 1, 1, 16, 1, 0); endtask
    task automatic test_r8_chunk_zero();  run_xfer("R8 chunk zero", 32'h1100, 2, 2, 1, 1, 0, 0, 0); endtask
    task automatic test_r10_busy_start(); run_xfer("R10 busy start", 32'h2000, 34, 2, 0, 0, 0, 0, 1); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        test_r1_zero();
        test_r2_memory();
        test_r3_short_mem();
        test_r5_stall();
        test_r7_single();
        test_r8_chunk();
        test_r8_chunk_stall();
        test_r8_chunk_zero();
        test_r10_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule